// File: doc/BRIEF.md
# BCD Limit Go/No-Go Classifier

This block grades a finished four-digit decimal measurement against two operator-set bounds, a ceiling and a floor. All three values arrive as packed BCD, with four bits per digit and the most significant digit in the top nibble. Each bound is compared directly in BCD. The digits are examined from the most significant one downward, and the first pair of digits that differ decides the result. No conversion to binary takes place.

The outcome drives three lamps: red for over the ceiling, yellow for under the floor, and green for within bounds. Exactly one lamp is lit. If both faults hold at once, which happens when the floor is set above the ceiling, red wins. The block also brings out the two raw fault flags. The lamps and the flags are registered. They change only on the clock edge where the measurement-complete strobe is high, and they hold their values between strobes. A bound digit whose code is above 9 is read as 9.

Top module: `bcd_limit_judge`

## Requirements
- R1: After reset, and until the first strobe, all five outputs (`lamp_red`, `lamp_yellow`, `lamp_green`, `over_flag`, `under_flag`) are 0.
- R2: `over_flag` is 1 exactly when the count is strictly greater than the ceiling. An equal value gives 0.
- R3: `under_flag` is 1 exactly when the count is strictly less than the floor. An equal value gives 0.
- R4: When `over_flag` is 1, `lamp_red` is 1.
- R5: `lamp_yellow` is 1 exactly when `under_flag` is 1 and `over_flag` is 0.
- R6: `lamp_green` is 1 exactly when both flags are 0.
- R7: When the count is above the ceiling and below the floor at the same time, both flags are 1, only `lamp_red` is lit, and `lamp_yellow` is 0.
- R8: Digits are compared from the most significant nibble (bits 15:12) downward, and the first unequal digit decides. For example, 1999 is below 2000, and 2000 is above 1999.
- R9: On a clock edge with `meas_done` low, no output changes, whatever the data inputs do.
- R10: Any ceiling or floor digit with a code from 10 to 15 is compared as the digit 9. For example, ceiling 0x12A4 acts as 1294, and floor 0x00AF acts as 0099.
- R11: After any strobe, exactly one of the three lamps is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_done | input | 1 | High for one cycle when the count is complete |
| count_bcd | input | 16 | Measured value, four BCD digits |
| ceil_bcd | input | 16 | Upper bound, four BCD digits |
| floor_bcd | input | 16 | Lower bound, four BCD digits |
| lamp_red | output | 1 | Over-ceiling lamp |
| lamp_yellow | output | 1 | Under-floor lamp |
| lamp_green | output | 1 | Within-bounds lamp |
| over_flag | output | 1 | Count is above the ceiling |
| under_flag | output | 1 | Count is below the floor |

## Verification
The comparison itself is combinational. A single register stage sits between it and every output. All five results are therefore due on the clock edge that samples `meas_done` high, and they stay frozen until the next strobe. The bench drives the operands and the strobe on a falling edge and drops the strobe on the next falling edge. It reads the outputs on that same falling edge, half a cycle after the capturing rising edge. For the hold check, the operands are changed with the strobe low and held for several cycles. The outputs are then read again and must still show the old verdict.

// File: rtl/bcd_lim_pkg.sv
package bcd_lim_pkg;
    localparam int DIG_W   = 4;
    localparam int NUM_DIG = 4;
    localparam int CNT_W   = DIG_W * NUM_DIG;
    localparam int DIG_MAX = 9;

    // which relation a bound comparator reports
    typedef enum logic {REL_ABOVE, REL_BELOW} rel_e;

    typedef struct packed {
        logic above;
        logic below;
        logic red;
        logic yellow;
        logic green;
    } verdict_t;
endpackage

// File: rtl/bcd_digit_cmp.sv
module bcd_digit_cmp
    import bcd_lim_pkg::*;
#(
    parameter int W = DIG_W
) (
    input  logic [W-1:0] meas_dig,
    input  logic [W-1:0] bound_dig,
    output logic         gt,
    output logic         lt
);
    localparam logic [W-1:0] TOP = W'(DIG_MAX);

    logic [W-1:0] bound_c;

    always_comb begin
        // R10: malformed bound digit saturates to 9
        bound_c = (bound_dig > TOP) ? TOP : bound_dig;
        gt      = meas_dig > bound_c;
        lt      = meas_dig < bound_c;
    end
endmodule

// File: rtl/bcd_bound_cmp.sv
module bcd_bound_cmp
    import bcd_lim_pkg::*;
#(
    parameter int   NDIG = NUM_DIG,
    parameter int   W    = DIG_W,
    parameter rel_e REL  = REL_ABOVE
) (
    input  logic [NDIG*W-1:0] meas,
    input  logic [NDIG*W-1:0] bound,
    output logic              hit
);
    logic [NDIG-1:0] gt_v;
    logic [NDIG-1:0] lt_v;
    logic [NDIG-1:0] pick_v;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        bcd_digit_cmp #(.W(W)) i_dig (
            .meas_dig (meas[g*W +: W]),
            .bound_dig(bound[g*W +: W]),
            .gt       (gt_v[g]),
            .lt       (lt_v[g])
        );
    end

    if (REL == REL_ABOVE) begin : g_above
        assign pick_v = gt_v;
    end else begin : g_below
        assign pick_v = lt_v;
    end

    // R8: the most significant unequal digit decides
    always_comb begin
        logic decided;
        decided = 1'b0;
        hit     = 1'b0;
        for (int i = NDIG - 1; i >= 0; i--) begin
            if (!decided && (gt_v[i] || lt_v[i])) begin
                decided = 1'b1;
                hit     = pick_v[i];
            end
        end
    end
endmodule

// File: rtl/bcd_limit_judge.sv
module bcd_limit_judge
    import bcd_lim_pkg::*;
#(
    parameter int NDIG = NUM_DIG,
    parameter int W    = DIG_W,
    localparam int VW  = NDIG * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          meas_done,
    input  logic [VW-1:0] count_bcd,
    input  logic [VW-1:0] ceil_bcd,
    input  logic [VW-1:0] floor_bcd,
    output logic          lamp_red,
    output logic          lamp_yellow,
    output logic          lamp_green,
    output logic          over_flag,
    output logic          under_flag
);
    logic     over_hit;
    logic     under_hit;
    verdict_t state_d;
    verdict_t state_q;

    bcd_bound_cmp #(.NDIG(NDIG), .W(W), .REL(REL_ABOVE)) i_ceil_cmp (
        .meas (count_bcd),
        .bound(ceil_bcd),
        .hit  (over_hit)
    );

    bcd_bound_cmp #(.NDIG(NDIG), .W(W), .REL(REL_BELOW)) i_floor_cmp (
        .meas (count_bcd),
        .bound(floor_bcd),
        .hit  (under_hit)
    );

    always_comb begin
        state_d = state_q;
        if (meas_done) begin
            state_d.above  = over_hit;
            state_d.below  = under_hit;
            state_d.red    = over_hit;
            state_d.yellow = under_hit && !over_hit;
            state_d.green  = !over_hit && !under_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lamp_red    = state_q.red;
    assign lamp_yellow = state_q.yellow;
    assign lamp_green  = state_q.green;
    assign over_flag   = state_q.above;
    assign under_flag  = state_q.below;

    // R11
    lamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> $countones({lamp_red, lamp_yellow, lamp_green}) == 1);

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_done |=> $stable({lamp_red, lamp_yellow, lamp_green, over_flag, under_flag}));

    // R4
    red_follows_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done && over_hit |=> lamp_red && over_flag);

    // R5
    yellow_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_yellow |-> under_flag && !over_flag);

    // R6
    green_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_green |-> !under_flag && !over_flag);

    // R7
    red_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done && over_hit && under_hit |=> lamp_red && !lamp_yellow);
endmodule

// File: tb/test_bcd_limit_judge.sv
`timescale 1ns/1ps
module test_bcd_limit_judge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_done = 1'b0;
    logic [15:0] count_bcd = '0;
    logic [15:0] ceil_bcd = '0;
    logic [15:0] floor_bcd = '0;
    logic        lamp_red, lamp_yellow, lamp_green, over_flag, under_flag;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bcd_limit_judge i_bcd_limit_judge (
        .clk(clk), .rst_n(rst_n), .meas_done(meas_done),
        .count_bcd(count_bcd), .ceil_bcd(ceil_bcd), .floor_bcd(floor_bcd),
        .lamp_red(lamp_red), .lamp_yellow(lamp_yellow), .lamp_green(lamp_green),
        .over_flag(over_flag), .under_flag(under_flag)
    );

    // {count, ceiling, floor, expected over, expected under}
    localparam int NV = 13;
    localparam logic [49:0] VEC [NV] = '{
        {16'h0500, 16'h0900, 16'h0100, 1'b0, 1'b0},  // R6 within
        {16'h0900, 16'h0900, 16'h0100, 1'b0, 1'b0},  // R2 equal ceiling
        {16'h0901, 16'h0900, 16'h0100, 1'b1, 1'b0},  // R2 above
        {16'h0100, 16'h0900, 16'h0100, 1'b0, 1'b0},  // R3 equal floor
        {16'h0099, 16'h0900, 16'h0100, 1'b0, 1'b1},  // R3 below, R5
        {16'h1999, 16'h5000, 16'h2000, 1'b0, 1'b1},  // R8
        {16'h2000, 16'h1999, 16'h0000, 1'b1, 1'b0},  // R8, R4
        {16'h0500, 16'h0100, 16'h0900, 1'b1, 1'b1},  // R7
        {16'h1295, 16'h12A4, 16'h0000, 1'b1, 1'b0},  // R10
        {16'h1294, 16'h12A4, 16'h0000, 1'b0, 1'b0},  // R10
        {16'h0098, 16'h9999, 16'h00AF, 1'b0, 1'b1},  // R10
        {16'h0099, 16'h9999, 16'h00AF, 1'b0, 1'b0},  // R10
        {16'h9999, 16'hFFFF, 16'h0000, 1'b0, 1'b0}   // R10
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {red,yel,grn,over,under} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] expect_out(input logic ov, input logic un);
        return {ov, un && !ov, !ov && !un, ov, un};
    endfunction

    function automatic logic [4:0] outs();
        return {lamp_red, lamp_yellow, lamp_green, over_flag, under_flag};
    endfunction

    task automatic strobe(input logic [15:0] c, input logic [15:0] u, input logic [15:0] l);
        @(negedge clk);
        count_bcd = c; ceil_bcd = u; floor_bcd = l; meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #20000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [4:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset", outs(), 5'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", outs(), 5'b0);

        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            v = VEC[i];
            strobe(v[49:34], v[33:18], v[17:2]);
            check($sformatf("R2/R3/R4/R5/R6/R7/R8/R10 vec %0d", i), outs(), expect_out(v[1], v[0]));
            n_run++;
            if ($countones({lamp_red, lamp_yellow, lamp_green}) != 1) begin
                n_fail++;
                $display("FAIL R11 vec %0d: lamps actual %b expected one-hot", i,
                         {lamp_red, lamp_yellow, lamp_green});
            end
        end

        // R9: operands change without a strobe, verdict holds
        strobe(16'h0901, 16'h0900, 16'h0100);
        held = outs();
        check("R9 setup", held, expect_out(1'b1, 1'b0));
        @(negedge clk);
        count_bcd = 16'h0050; ceil_bcd = 16'h0900; floor_bcd = 16'h0100;
        repeat (4) @(negedge clk);
        check("R9 hold below", outs(), held);
        count_bcd = 16'h0500;
        repeat (3) @(negedge clk);
        check("R9 hold within", outs(), held);

        // R7 directed: floor above ceiling, boundary between them
        strobe(16'h0300, 16'h0299, 16'h0301);
        check("R7 crossed bounds", outs(), 5'b10011);

        // R1 again: reset mid-run clears the verdict
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", outs(), 5'b0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule